// File: doc/BRIEF.md
# FM Operator Envelope Generator

This block produces the attenuation curve for every operator slot of a time-multiplexed FM synthesis voice engine. Each slot keeps a 10-bit attenuation, where 0 is full level and 0x3FF is silence, together with a phase: attack, decay, sustain or release. Each slot has its own programmed rates, sustain level, key-scale setting and key code. These are written through a slot-addressed configuration port. Key-on and key-off events are posted through a separate slot-addressed port.

One slot is serviced on each pulse of `upd_stb`. The surrounding engine raises this strobe once every third operator clock. The slots are visited in ascending order. After the last slot, a shared envelope counter advances by one. This counter decides whether the serviced slot moves in this visit, and by how much. Attack follows an exponential curve: the step is proportional to the remaining distance to full level. The other phases add a fixed step and saturate at silence. Any slot's current state can be read at any time through a combinational read port.

Top module: `fm_env_gen`

## Requirements
- R1: After reset, every slot is in release (`rd_phase` = 3) with attenuation 0x3FF, `svc_slot` is 0 and `env_cnt` is 0. The phase codes are attack=0, decay=1, sustain=2, release=3.
- R2: Each `upd_stb` pulse services the slot shown on `svc_slot`, then advances it by one. From slot NUM_SLOTS-1 it wraps to 0, and on that wrap `env_cnt` increments. Neither value changes without a strobe.
- R3: The effective rate of a phase is 0 when its programmed 5-bit rate is 0. Otherwise it is min(63, 2·rate + (key_code >> (3 − key_scale))).
- R4: Let the shift be (47 − rate) >> 2 for an effective rate below 48, and 0 otherwise. A serviced slot changes only when the low `shift` bits of `env_cnt` are all zero. The step index is (env_cnt >> shift) & 7.
- R5: The increment for rate r and step s is as follows. For r < 2 it is 0, and for r ≥ 60 it is 8. For 8 ≤ r < 48 it is taken from row r&3 of the low rows: 0:{0,1,0,1,0,1,0,1}, 1:{0,1,0,1,1,1,0,1}, 2:{0,1,1,1,0,1,1,1}, 3:{0,1,1,1,1,1,1,1}. For 2 ≤ r < 8 it is taken from low row 2 if (r & 6) == 6, and from low row 0 otherwise. For 48 ≤ r < 60 it is taken from row r&3 of the high rows {1,1,1,1,1,1,1,1}, {1,1,1,2,1,1,1,2}, {1,2,1,2,1,2,1,2}, {1,2,2,2,1,2,2,2}, then shifted left by (r − 48) >> 2.
- R6: In attack, a gated update lowers the attenuation by ceil((att + 1)·inc / 16). If that amount is at least the current attenuation, the attenuation becomes 0 and the phase becomes decay.
- R7: In decay, sustain and release, a gated update adds the increment, saturating at 0x3FF.
- R8: A slot in decay whose attenuation is at or above its sustain threshold switches to sustain at its next service, and that visit then uses the sustain rate. The threshold is sl·32, except that sl = 15 gives 0x3FF.
- R9: A posted key event is applied at the slot's next service, in place of that visit's rate update. Key-off enters release and leaves the attenuation unchanged. Key-on with an effective attack rate of 62 or more sets the attenuation to 0 and the phase to decay. Any other key-on enters attack and leaves the attenuation unchanged. If several events are posted before the service, only the last one is applied.
- R10: The release phase uses the programmed 4-bit release value rr as the 5-bit rate 2·rr + 1.
- R11: Without a strobe, no slot's attenuation or phase changes, and that includes cycles with configuration writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_stb | input | 1 | Service the current slot |
| cfg_we | input | 1 | Write configuration of `cfg_slot` |
| cfg_slot | input | SLOT_W | Slot addressed by the configuration write |
| cfg_ar | input | 5 | Attack rate |
| cfg_dr | input | 5 | Decay rate |
| cfg_sr | input | 5 | Sustain rate |
| cfg_rr | input | 4 | Release value |
| cfg_sl | input | 4 | Sustain level |
| cfg_ks | input | 2 | Key-scale setting |
| cfg_kc | input | 5 | Key code |
| key_stb | input | 1 | Post a key event |
| key_slot | input | SLOT_W | Slot of the key event |
| key_on | input | 1 | 1 = key-on, 0 = key-off |
| rd_slot | input | SLOT_W | Slot to read |
| rd_att | output | 10 | Attenuation of `rd_slot` |
| rd_phase | output | 2 | Phase of `rd_slot` |
| svc_slot | output | SLOT_W | Slot the next strobe services |
| env_cnt | output | CNT_W | Shared envelope counter |

## Verification
The serviced slot's attenuation and phase, `svc_slot` and `env_cnt` are all registered at the clock edge where `upd_stb` is high. They are therefore due one edge after the strobe. A posted key event is stored at its own edge and takes effect only at the edge that next services that slot. `rd_att` and `rd_phase` follow `rd_slot` with no delay. The bench drives every input at falling edges and samples just after the falling edge that follows the strobe's edge. It keeps its own copy of the slot pointer and counter, so it knows exactly which counter value each visit saw.

// File: rtl/fm_env_pkg.sv
package fm_env_pkg;

  localparam int ATT_W = 10;
  localparam logic [ATT_W-1:0] ATT_MAX = '1;

  typedef enum logic [1:0] {
    PH_ATK = 2'd0,
    PH_DEC = 2'd1,
    PH_SUS = 2'd2,
    PH_REL = 2'd3
  } env_phase_e;

  typedef struct packed {
    logic [4:0] ar;
    logic [4:0] dr;
    logic [4:0] sr;
    logic [3:0] rr;
    logic [3:0] sl;
    logic [1:0] ks;
    logic [4:0] kc;
  } slot_cfg_t;

  // scaled rate, clamped to the 6-bit range
  function automatic logic [5:0] eff_rate(input logic [4:0] r, input logic [4:0] kc,
                                          input logic [1:0] ks);
    logic [6:0] s;
    if (r == 5'd0) return 6'd0;
    s = {1'b0, r, 1'b0} + {2'b00, (kc >> (2'd3 - ks))};
    return (s > 7'd63) ? 6'd63 : s[5:0];
  endfunction

  // number of low counter bits that must be zero for an update
  function automatic logic [3:0] rate_shift(input logic [5:0] r);
    logic [5:0] d;
    d = 6'd47 - r;
    return (r < 6'd48) ? d[5:2] : 4'd0;
  endfunction

  function automatic logic [3:0] inc_lookup(input logic [5:0] r, input logic [2:0] step);
    logic [7:0] m;
    logic [1:0] row;
    logic [1:0] base;
    logic [3:0] sh;
    if (r < 6'd2) return 4'd0;
    if (r >= 6'd60) return 4'd8;
    if (r < 6'd48) begin
      row = (r < 6'd8) ? (((r[2:1]) == 2'b11) ? 2'd2 : 2'd0) : r[1:0];
      unique case (row)
        2'd0: m = 8'hAA;
        2'd1: m = 8'hBA;
        2'd2: m = 8'hEE;
        default: m = 8'hFE;
      endcase
      return {3'b000, m[step]};
    end
    unique case (r[1:0])
      2'd0: m = 8'h00;
      2'd1: m = 8'h88;
      2'd2: m = 8'hAA;
      default: m = 8'hEE;
    endcase
    base = 2'd1 + {1'b0, m[step]};
    sh = {2'b00, r[3:2]} - 4'd0;
    sh = {2'b00, (r - 6'd48) >> 2}[3:0];
    return {2'b00, base} << sh;
  endfunction

  function automatic logic [ATT_W-1:0] sustain_full(input logic [3:0] sl);
    return (sl == 4'hF) ? ATT_MAX : {1'b0, sl, 5'b00000};
  endfunction

  // attack step: rounded-up sixteenth of (att+1)*inc
  function automatic logic [ATT_W-1:0] attack_dec(input logic [ATT_W-1:0] att,
                                                  input logic [3:0] inc);
    logic [14:0] p;
    p = ({5'b00000, att} + 15'd1) * {11'b0, inc} + 15'd15;
    return p[13:4];
  endfunction

endpackage

// File: rtl/fm_env_sched.sv
module fm_env_sched #(
  parameter int NUM_SLOTS = 24,
  parameter int CNT_W     = 15,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_stb,
  output logic [SLOT_W-1:0] slot,
  output logic [CNT_W-1:0]  cnt
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= '0;
      cnt  <= '0;
    end else if (upd_stb) begin
      if (slot == LAST) begin
        slot <= '0;
        cnt  <= cnt + CNT_W'(1);
      end else begin
        slot <= slot + SLOT_W'(1);
      end
    end
  end
endmodule

// File: rtl/fm_env_rate.sv
module fm_env_rate
  import fm_env_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  slot_cfg_t         cfg,
  input  env_phase_e        ph,
  input  logic [CNT_W-1:0]  cnt,
  output logic              gate,
  output logic [3:0]        inc,
  output logic              atk_instant
);
  logic [4:0]       raw;
  logic [5:0]       rate;
  logic [3:0]       sh;
  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] shifted;

  always_comb begin
    unique case (ph)
      PH_ATK:  raw = cfg.ar;
      PH_DEC:  raw = cfg.dr;
      PH_SUS:  raw = cfg.sr;
      default: raw = {cfg.rr, 1'b1};
    endcase
    rate        = eff_rate(raw, cfg.kc, cfg.ks);
    sh          = rate_shift(rate);
    mask        = (CNT_W'(1) << sh) - CNT_W'(1);
    gate        = (cnt & mask) == '0;
    shifted     = cnt >> sh;
    inc         = inc_lookup(rate, shifted[2:0]);
    atk_instant = eff_rate(cfg.ar, cfg.kc, cfg.ks) >= 6'd62;
  end
endmodule

// File: rtl/fm_env_step.sv
module fm_env_step
  import fm_env_pkg::*;
(
  input  logic [ATT_W-1:0] att,
  input  env_phase_e       ph,
  input  logic             gate,
  input  logic [3:0]       inc,
  input  logic             key_apply,
  input  logic             key_kind,
  input  logic             atk_instant,
  output logic [ATT_W-1:0] att_nx,
  output env_phase_e       ph_nx
);
  logic [ATT_W-1:0] dec;
  logic [ATT_W:0]   sum;

  always_comb begin
    att_nx = att;
    ph_nx  = ph;
    dec    = attack_dec(att, inc);
    sum    = {1'b0, att} + {{(ATT_W-3){1'b0}}, inc};
    if (key_apply) begin
      if (!key_kind) begin
        ph_nx = PH_REL;
      end else if (atk_instant) begin
        att_nx = '0;
        ph_nx  = PH_DEC;
      end else begin
        ph_nx = PH_ATK;
      end
    end else if (gate) begin
      if (ph == PH_ATK) begin
        if (dec >= att) begin
          att_nx = '0;
          ph_nx  = PH_DEC;
        end else begin
          att_nx = att - dec;
        end
      end else begin
        att_nx = sum[ATT_W] ? ATT_MAX : sum[ATT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/fm_env_gen.sv
module fm_env_gen
  import fm_env_pkg::*;
#(
  parameter int NUM_SLOTS = 24,
  parameter int CNT_W     = 15,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_stb,
  input  logic              cfg_we,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [4:0]        cfg_ar,
  input  logic [4:0]        cfg_dr,
  input  logic [4:0]        cfg_sr,
  input  logic [3:0]        cfg_rr,
  input  logic [3:0]        cfg_sl,
  input  logic [1:0]        cfg_ks,
  input  logic [4:0]        cfg_kc,
  input  logic              key_stb,
  input  logic [SLOT_W-1:0] key_slot,
  input  logic              key_on,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [9:0]        rd_att,
  output logic [1:0]        rd_phase,
  output logic [SLOT_W-1:0] svc_slot,
  output logic [CNT_W-1:0]  env_cnt
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

  slot_cfg_t        cfg_q  [NUM_SLOTS];
  logic [ATT_W-1:0] att_q  [NUM_SLOTS];
  env_phase_e       ph_q   [NUM_SLOTS];
  logic [1:0]       pend_q [NUM_SLOTS];

  slot_cfg_t        cfg_new;
  slot_cfg_t        cfg_cur;
  logic [ATT_W-1:0] att_cur;
  env_phase_e       ph_cur;
  env_phase_e       ph_eff;
  logic [1:0]       pend_cur;
  logic             key_apply;
  logic             gate_open;
  logic [3:0]       inc;
  logic             atk_instant;
  logic [ATT_W-1:0] att_nx;
  env_phase_e       ph_nx;
  logic             rd_ok;

  always_comb begin
    cfg_new.ar = cfg_ar;
    cfg_new.dr = cfg_dr;
    cfg_new.sr = cfg_sr;
    cfg_new.rr = cfg_rr;
    cfg_new.sl = cfg_sl;
    cfg_new.ks = cfg_ks;
    cfg_new.kc = cfg_kc;
  end

  fm_env_sched #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W), .SLOT_W(SLOT_W)) sched_i (
    .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .slot(svc_slot), .cnt(env_cnt)
  );

  // state of the slot under service
  assign cfg_cur   = cfg_q[svc_slot];
  assign att_cur   = att_q[svc_slot];
  assign ph_cur    = ph_q[svc_slot];
  assign pend_cur  = pend_q[svc_slot];
  assign key_apply = pend_cur[1];
  assign ph_eff    = (ph_cur == PH_DEC && att_cur >= sustain_full(cfg_cur.sl)) ? PH_SUS : ph_cur;

  fm_env_rate #(.CNT_W(CNT_W)) rate_i (
    .cfg(cfg_cur), .ph(ph_eff), .cnt(env_cnt),
    .gate(gate_open), .inc(inc), .atk_instant(atk_instant)
  );

  fm_env_step step_i (
    .att(att_cur), .ph(ph_eff), .gate(gate_open), .inc(inc),
    .key_apply(key_apply), .key_kind(pend_cur[0]), .atk_instant(atk_instant),
    .att_nx(att_nx), .ph_nx(ph_nx)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic hit_cfg, hit_key, hit_svc;
    assign hit_cfg = cfg_we  && (cfg_slot == SLOT_W'(g));
    assign hit_key = key_stb && (key_slot == SLOT_W'(g));
    assign hit_svc = upd_stb && (svc_slot == SLOT_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[g]  <= '0;
        att_q[g]  <= ATT_MAX;
        ph_q[g]   <= PH_REL;
        pend_q[g] <= 2'b00;
      end else begin
        if (hit_cfg) cfg_q[g] <= cfg_new;
        if (hit_key)      pend_q[g] <= {1'b1, key_on};
        else if (hit_svc) pend_q[g] <= 2'b00;
        if (hit_svc) begin
          att_q[g] <= att_nx;
          ph_q[g]  <= ph_nx;
        end
      end
    end

    // R11: state only moves on a strobe
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_stb |=> $stable(att_q[g]) && $stable(ph_q[g]));
  end

  assign rd_ok    = rd_slot <= LAST;
  assign rd_att   = rd_ok ? att_q[rd_slot] : ATT_MAX;
  assign rd_phase = rd_ok ? ph_q[rd_slot] : PH_REL;

  // R2: pointer wraps after the last slot and the counter steps
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb && svc_slot == LAST |=> svc_slot == '0 && env_cnt == $past(env_cnt) + CNT_W'(1));
  p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb |=> $stable(env_cnt) && $stable(svc_slot));
  // R4: closed gate leaves the serviced slot untouched
  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb && !key_apply && !gate_open |-> att_nx == att_cur);
  // R5: increment never exceeds 8
  p_inc_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |-> inc <= 4'd8);
  // R6: attack only lowers attenuation
  p_attack_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb && !key_apply && ph_eff == PH_ATK |-> att_nx <= att_cur);
  // R7: other phases only raise it, without wrapping
  p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb && !key_apply && ph_eff != PH_ATK |-> att_nx >= att_cur);
  // R9: instant attack lands at full level in decay
  p_instant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb && key_apply && pend_cur[0] && atk_instant |=> rd_slot != $past(svc_slot) ||
      (rd_att == '0 && rd_phase == 2'd1));
endmodule

// File: tb/fm_env_gen_tb_top.sv
module fm_env_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 24;
  localparam int SW = 5;
  localparam int CW = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic upd_stb = 0, cfg_we = 0, key_stb = 0, key_on = 0;
  logic [SW-1:0] cfg_slot = '0, key_slot = '0, rd_slot = '0;
  logic [4:0] cfg_ar = '0, cfg_dr = '0, cfg_sr = '0, cfg_kc = '0;
  logic [3:0] cfg_rr = '0, cfg_sl = '0;
  logic [1:0] cfg_ks = '0;
  logic [9:0] rd_att;
  logic [1:0] rd_phase;
  logic [SW-1:0] svc_slot;
  logic [CW-1:0] env_cnt;

  int n_chk = 0, n_bad = 0;
  int bptr = 0, bcnt = 0, last_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fm_env_gen dut_i (
    .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .cfg_ar(cfg_ar), .cfg_dr(cfg_dr), .cfg_sr(cfg_sr), .cfg_rr(cfg_rr), .cfg_sl(cfg_sl),
    .cfg_ks(cfg_ks), .cfg_kc(cfg_kc), .key_stb(key_stb), .key_slot(key_slot),
    .key_on(key_on), .rd_slot(rd_slot), .rd_att(rd_att), .rd_phase(rd_phase),
    .svc_slot(svc_slot), .env_cnt(env_cnt)
  );

  // columns: ar, ks, kc, expected attenuation, expected phase after key-on
  localparam int TBL [8][5] = '{
    '{31, 0,  0,    0, 1},
    '{30, 3,  1, 1023, 0},
    '{30, 3,  2,    0, 1},
    '{ 0, 3, 31, 1023, 0},
    '{28, 2, 16,    0, 1},
    '{29, 1, 15, 1023, 0},
    '{29, 0, 31, 1023, 0},
    '{29, 0,  8, 1023, 0}
  };

  localparam int LO [4][8] = '{'{0,1,0,1,0,1,0,1}, '{0,1,0,1,1,1,0,1},
                                '{0,1,1,1,0,1,1,1}, '{0,1,1,1,1,1,1,1}};
  localparam int HI [4][8] = '{'{1,1,1,1,1,1,1,1}, '{1,1,1,2,1,1,1,2},
                                '{1,2,1,2,1,2,1,2}, '{1,2,2,2,1,2,2,2}};

  function automatic int b_eff(int r, int kc, int ks);
    int v;
    if (r == 0) return 0;
    v = 2 * r + (kc >> (3 - ks));
    return (v > 63) ? 63 : v;
  endfunction

  function automatic int b_inc(int r, int step);
    if (r < 2) return 0;
    if (r >= 60) return 8;
    if (r < 8) return LO[((r & 6) == 6) ? 2 : 0][step];
    if (r < 48) return LO[r % 4][step];
    return HI[r % 4][step] << ((r - 48) / 4);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk) upd_stb = 1'b1;
    @(negedge clk) upd_stb = 1'b0;
    last_cnt = bcnt;
    if (bptr == NS - 1) begin bptr = 0; bcnt++; end else bptr++;
  endtask

  task automatic service(int s);
    while (bptr != s) strobe();
    strobe();
  endtask

  task automatic cfg(int s, int ar, int dr, int sr, int rr, int sl, int ks, int kc);
    @(negedge clk);
    cfg_we = 1'b1; cfg_slot = SW'(s);
    cfg_ar = 5'(ar); cfg_dr = 5'(dr); cfg_sr = 5'(sr); cfg_rr = 4'(rr);
    cfg_sl = 4'(sl); cfg_ks = 2'(ks); cfg_kc = 5'(kc);
    @(negedge clk) cfg_we = 1'b0;
  endtask

  task automatic key(int s, bit on);
    @(negedge clk);
    key_stb = 1'b1; key_slot = SW'(s); key_on = on;
    @(negedge clk) key_stb = 1'b0;
  endtask

  task automatic look(int s, output int att, output int ph);
    rd_slot = SW'(s);
    #1;
    att = int'(rd_att);
    ph = int'(rd_phase);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int a, p, ea, ep, r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int s = 0; s < NS; s++) begin
      look(s, a, p);
      chk("R1 att", a, 1023);
      chk("R1 phase", p, 3);
    end
    chk("R1 svc_slot", int'(svc_slot), 0);
    chk("R1 env_cnt", int'(env_cnt), 0);

    // R9/R3 key-on outcome table, one slot per vector
    for (int v = 0; v < 8; v++) begin
      cfg(v, TBL[v][0], 0, 0, 0, 0, TBL[v][1], TBL[v][2]);
      key(v, 1'b1);
      service(v);
      look(v, a, p);
      chk("R9/R3 keyon att", a, TBL[v][3]);
      chk("R9/R3 keyon phase", p, TBL[v][4]);
    end

    // R10/R7 release at fastest rate, saturation at 0x3FF
    cfg(10, 31, 0, 0, 15, 0, 0, 0);
    key(10, 1'b1);
    service(10);
    key(10, 1'b0);
    service(10);
    look(10, a, p);
    chk("R9 keyoff att", a, 0);
    chk("R9 keyoff phase", p, 3);
    r = b_eff(2 * 15 + 1, 0, 0);
    for (int k = 1; k <= 129; k++) begin
      service(10);
      ea = 8 * k; if (ea > 1023) ea = 1023;
      if (k == 1 || k == 127 || k == 128 || k == 129) begin
        look(10, a, p);
        chk("R10/R7 release att", a, ea);
      end
    end
    chk("R10 release inc", b_inc(r, 0), 8);

    // R2 pointer and counter against the bench's own count
    chk("R2 svc_slot", int'(svc_slot), bptr);
    chk("R2 env_cnt", int'(env_cnt), bcnt);

    // R9 last posted event wins
    cfg(16, 31, 0, 0, 0, 0, 0, 0);
    key(16, 1'b1);
    key(16, 1'b0);
    service(16);
    look(16, a, p);
    chk("R9 last event att", a, 1023);
    chk("R9 last event phase", p, 3);

    // R4/R5 gated decay with a shift of one
    cfg(12, 31, 20, 0, 0, 15, 0, 0);
    key(12, 1'b1);
    service(12);
    ea = 0;
    r = b_eff(20, 0, 0);
    for (int k = 0; k < 40; k++) begin
      service(12);
      if ((last_cnt % 2) == 0) ea = ea + b_inc(r, (last_cnt >> 1) & 7);
      if (ea > 1023) ea = 1023;
      look(12, a, p);
      chk("R4/R5 decay att", a, ea);
      chk("R4 decay phase", p, 1);
    end

    // R6 exponential attack, then R8 decay into sustain
    cfg(14, 24, 31, 0, 0, 1, 0, 0);
    key(14, 1'b1);
    service(14);
    look(14, a, p);
    chk("R9 attack entry att", a, 1023);
    chk("R9 attack entry phase", p, 0);
    ea = 1023; ep = 0;
    for (int k = 0; k < 200 && ep == 0; k++) begin
      int inc, dec;
      service(14);
      inc = b_inc(b_eff(24, 0, 0), last_cnt & 7);
      dec = ((ea + 1) * inc + 15) / 16;
      if (dec >= ea) begin ea = 0; ep = 1; end else ea = ea - dec;
      look(14, a, p);
      chk("R6 attack att", a, ea);
      chk("R6 attack phase", p, ep);
    end
    chk("R6 reached decay", ep, 1);
    for (int k = 1; k <= 4; k++) service(14);
    look(14, a, p);
    chk("R8 decay att", a, 32);
    chk("R8 still decay", p, 1);
    service(14);
    look(14, a, p);
    chk("R8 sustain att", a, 32);
    chk("R8 sustain phase", p, 2);

    // R11 no strobe: nothing moves, even across a config write
    look(12, ea, ep);
    cfg(12, 31, 31, 31, 15, 0, 3, 31);
    repeat (20) @(negedge clk);
    look(12, a, p);
    chk("R11 att held", a, ea);
    chk("R11 phase held", p, ep);
    chk("R11 svc_slot held", int'(svc_slot), bptr);
    chk("R11 env_cnt held", int'(env_cnt), bcnt);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule